// File: doc/BRIEF.md
# Interleaved Dual-Bank Memory Arbiter

This block shares one memory between a processor port and a read-only video fetch port. The memory is split into two banks. Fixed-size address chunks alternate between the banks, and each bank is given its own address every cycle. When the two requesters land in different banks, both accesses complete in the same cycle. The processor is held back only when it lands in the bank that the video fetch is reading in that cycle. The video fetch always wins a conflict and is never delayed.

The processor side uses a valid/ready handshake with byte-enabled writes. It must keep its request stable while ready is low. The video side presents a request and an address each cycle it wants a word, and gets the word back one cycle later with a valid flag. Both banks are internal synchronous RAMs with registered read data.

Top module: `ilv_mem_arbiter`

## Requirements
- R1: The bank of a byte address is bit log2(CHUNK_BYTES) of the address, which is bit 4 for the default 16-byte chunk. So addresses A and A+CHUNK_BYTES fall in different banks, and addresses A and A+2*CHUNK_BYTES fall in the same bank.
- R2: When cpu_valid and dma_req are both high and they select different banks, cpu_ready is high and both accesses complete in that cycle.
- R3: When cpu_valid and dma_req are both high and they select the same bank, cpu_ready is low. The held processor request completes in the first cycle in which the video fetch is idle or in the other bank.
- R4: Every cycle with dma_req high is followed one cycle later by dma_rvalid high, with dma_rdata equal to the memory word at dma_addr. dma_rvalid is low after a cycle without dma_req.
- R5: When dma_req is low, cpu_ready is high for any processor address.
- R6: cpu_rvalid is high exactly in the cycle after a processor read is accepted (cpu_valid, cpu_ready, cpu_we low). In that cycle cpu_rdata holds the word that was addressed.
- R7: A processor write updates only the bytes whose cpu_be bit is set. Bit i covers data bits 8i+7 down to 8i.
- R8: Every word read on either port equals the word most recently written to that address through the processor port, under any mix of traffic.
- R9: While rst is high, and in the cycle after it, cpu_rvalid and dma_rvalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Processor request accepted this cycle |
| cpu_addr | input | ADDR_W | Processor byte address (word aligned) |
| cpu_we | input | 1 | Processor write when high, read when low |
| cpu_be | input | DATA_W/8 | Processor byte enables for writes |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data |
| cpu_rvalid | output | 1 | Processor read data valid |
| dma_req | input | 1 | Video fetch request |
| dma_addr | input | ADDR_W | Video fetch byte address (word aligned) |
| dma_rdata | output | DATA_W | Video fetch read data |
| dma_rvalid | output | 1 | Video fetch read data valid |

## Verification
The checker evaluates the handshake on every cycle. It confirms that a same-bank clash drops cpu_ready, that split banks or an idle fetch leave it high, and that each read valid flag follows exactly one cycle after an accepted read. Data content cannot be seen by a property. Only the bench scenarios show that the interleave mapping, byte-enable merging and concurrent traffic leave every word intact; these scenarios compare each read against a flat reference memory. The bench scenarios also show that opposite-bank streams run with zero stall cycles.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int NUM_BANKS = 2;

  // Which requester drives a bank in the current cycle
  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_DMA  = 2'd1,
    PORT_CPU  = 2'd2
  } port_sel_e;
endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int CHUNK_BYTES = 16
) (
  input  logic [ADDR_W-1:0]                  addr,
  output logic                               bank,
  output logic [ADDR_W-2-$clog2(DATA_W/8):0] row
);
  localparam int BYTE_LG  = $clog2(DATA_W/8);
  localparam int CHUNK_LG = $clog2(CHUNK_BYTES);

  assign bank = addr[CHUNK_LG];

  // The in-bank word index drops the bank bit and the byte offset
  generate
    if (CHUNK_LG > BYTE_LG) begin : g_multi_word_chunk
      assign row = {addr[ADDR_W-1:CHUNK_LG+1], addr[CHUNK_LG-1:BYTE_LG]};
    end else begin : g_single_word_chunk
      assign row = addr[ADDR_W-1:CHUNK_LG+1];
    end
  endgenerate
endmodule

// File: rtl/ilv_bank_ram.sv
module ilv_bank_ram #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 9
) (
  input  logic                clk,
  input  logic                en,
  input  logic                we,
  input  logic [DATA_W/8-1:0] be,
  input  logic [ROW_W-1:0]    row,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);
  localparam int BE_W  = DATA_W / 8;
  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single port, read-first, byte-write layout suited to block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int i = 0; i < BE_W; i++) begin
          if (be[i]) mem[row][i*8 +: 8] <= wdata[i*8 +: 8];
        end
      end
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/ilv_conflict.sv
module ilv_conflict
  import ilv_pkg::*;
(
  input  logic                            cpu_valid,
  input  logic                            cpu_bank,
  input  logic                            dma_req,
  input  logic                            dma_bank,
  output logic                            cpu_ready,
  output logic                            cpu_fire,
  output port_sel_e [NUM_BANKS-1:0]       owner
);
  // Fetch side has absolute priority on its bank
  assign cpu_ready = !(dma_req && (dma_bank == cpu_bank));
  assign cpu_fire  = cpu_valid && cpu_ready;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_owner
      always_comb begin
        if (dma_req && (dma_bank == 1'(b)))
          owner[b] = PORT_DMA;
        else if (cpu_fire && (cpu_bank == 1'(b)))
          owner[b] = PORT_CPU;
        else
          owner[b] = PORT_NONE;
      end
    end
  endgenerate
endmodule

// File: rtl/ilv_bank_slice.sv
module ilv_bank_slice
  import ilv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 9
) (
  input  logic                clk,
  input  port_sel_e           owner,
  input  logic [ROW_W-1:0]    dma_row,
  input  logic [ROW_W-1:0]    cpu_row,
  input  logic                cpu_we,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   rdata
);
  logic             ram_en;
  logic             ram_we;
  logic [ROW_W-1:0] ram_row;

  always_comb begin
    ram_en  = (owner != PORT_NONE);
    ram_we  = (owner == PORT_CPU) && cpu_we;
    ram_row = (owner == PORT_DMA) ? dma_row : cpu_row;
  end

  ilv_bank_ram #(
    .DATA_W (DATA_W),
    .ROW_W  (ROW_W)
  ) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .be    (cpu_be),
    .row   (ram_row),
    .wdata (cpu_wdata),
    .rdata (rdata)
  );
endmodule

// File: rtl/ilv_mem_arbiter.sv
module ilv_mem_arbiter
  import ilv_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int CHUNK_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_we,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_rvalid,
  input  logic                dma_req,
  input  logic [ADDR_W-1:0]   dma_addr,
  output logic [DATA_W-1:0]   dma_rdata,
  output logic                dma_rvalid
);
  localparam int BYTE_LG = $clog2(DATA_W/8);
  localparam int ROW_W   = ADDR_W - 1 - BYTE_LG;

  logic                              cpu_bank, dma_bank;
  logic [ROW_W-1:0]                  cpu_row, dma_row;
  logic                              cpu_fire;
  port_sel_e [NUM_BANKS-1:0]         owner;
  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_rdata;
  logic                              cpu_rbank, dma_rbank;
  logic                              cpu_rvalid_q, dma_rvalid_q;

  ilv_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHUNK_BYTES(CHUNK_BYTES)) u_map_cpu (
    .addr (cpu_addr),
    .bank (cpu_bank),
    .row  (cpu_row)
  );

  ilv_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHUNK_BYTES(CHUNK_BYTES)) u_map_dma (
    .addr (dma_addr),
    .bank (dma_bank),
    .row  (dma_row)
  );

  ilv_conflict u_conflict (
    .cpu_valid (cpu_valid),
    .cpu_bank  (cpu_bank),
    .dma_req   (dma_req),
    .dma_bank  (dma_bank),
    .cpu_ready (cpu_ready),
    .cpu_fire  (cpu_fire),
    .owner     (owner)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ilv_bank_slice #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_slice (
        .clk       (clk),
        .owner     (owner[b]),
        .dma_row   (dma_row),
        .cpu_row   (cpu_row),
        .cpu_we    (cpu_we),
        .cpu_be    (cpu_be),
        .cpu_wdata (cpu_wdata),
        .rdata     (bank_rdata[b])
      );
    end
  endgenerate

  // Return path: remember which bank each read went to
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid_q <= 1'b0;
      dma_rvalid_q <= 1'b0;
      cpu_rbank    <= 1'b0;
      dma_rbank    <= 1'b0;
    end else begin
      cpu_rvalid_q <= cpu_fire && !cpu_we;
      dma_rvalid_q <= dma_req;
      if (cpu_fire) cpu_rbank <= cpu_bank;
      if (dma_req)  dma_rbank <= dma_bank;
    end
  end

  assign cpu_rvalid = cpu_rvalid_q;
  assign dma_rvalid = dma_rvalid_q;
  assign cpu_rdata  = bank_rdata[cpu_rbank];
  assign dma_rdata  = bank_rdata[dma_rbank];
endmodule

// File: rtl/ilv_mem_arbiter_chk.sv
module ilv_mem_arbiter_chk #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int CHUNK_BYTES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic              cpu_rvalid,
  input logic              dma_req,
  input logic [ADDR_W-1:0] dma_addr,
  input logic              dma_rvalid
);
  localparam int CL = $clog2(CHUNK_BYTES);

  p_bank_clash_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && dma_req && (cpu_addr[CL] == dma_addr[CL])) |-> !cpu_ready);

  p_split_banks_go_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && dma_req && (cpu_addr[CL] != dma_addr[CL])) |-> cpu_ready);

  p_idle_fetch_free_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !dma_req) |-> cpu_ready);

  p_fetch_return_r4: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> dma_rvalid);

  p_fetch_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
    !dma_req |=> !dma_rvalid);

  p_cpu_read_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && !cpu_we) |=> cpu_rvalid);

  p_cpu_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
    !(cpu_valid && cpu_ready && !cpu_we) |=> !cpu_rvalid);

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!cpu_rvalid && !dma_rvalid));
endmodule

bind ilv_mem_arbiter ilv_mem_arbiter_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .CHUNK_BYTES (CHUNK_BYTES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_valid  (cpu_valid),
  .cpu_ready  (cpu_ready),
  .cpu_addr   (cpu_addr),
  .cpu_we     (cpu_we),
  .cpu_rvalid (cpu_rvalid),
  .dma_req    (dma_req),
  .dma_addr   (dma_addr),
  .dma_rvalid (dma_rvalid)
);

// File: tb/ilv_mem_arbiter_bench.sv
module ilv_mem_arbiter_bench;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int WORDS = 1 << (AW - 2);

  logic          clk = 1'b0;
  logic          rst;
  logic          cpu_valid, cpu_ready, cpu_we, cpu_rvalid;
  logic [AW-1:0] cpu_addr;
  logic [BW-1:0] cpu_be;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          dma_req, dma_rvalid;
  logic [AW-1:0] dma_addr;
  logic [DW-1:0] dma_rdata;

  always #10 clk = ~clk;

  ilv_mem_arbiter #(.ADDR_W(AW), .DATA_W(DW), .CHUNK_BYTES(16)) u_ilv_mem_arbiter (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_rdata(dma_rdata), .dma_rvalid(dma_rvalid)
  );

  logic [DW-1:0] ref_mem [WORDS];
  int            n_checks = 0;
  int            n_fails  = 0;
  int            stalls   = 0;
  logic          pend_cpu = 1'b0, pend_dma = 1'b0;
  logic [DW-1:0] exp_cpu, exp_dma;

  function automatic logic bank_of(input logic [AW-1:0] a);
    return a[4];
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [BW-1:0] be);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < BW; i++) if (be[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: check last cycle's returns, drive new inputs, predict ready
  task automatic cycle(input logic dv, input logic [AW-1:0] da,
                       input logic cv, input logic [AW-1:0] ca, input logic cwe,
                       input logic [BW-1:0] cbe, input logic [DW-1:0] cwd,
                       output logic acc);
    logic exp_rdy;
    string tag;
    @(negedge clk);
    chk(cpu_rvalid == pend_cpu, "R6 rvalid", DW'(cpu_rvalid), DW'(pend_cpu));
    if (pend_cpu) chk(cpu_rdata == exp_cpu, "R8 cpu data", cpu_rdata, exp_cpu);
    chk(dma_rvalid == pend_dma, "R4 rvalid", DW'(dma_rvalid), DW'(pend_dma));
    if (pend_dma) chk(dma_rdata == exp_dma, "R4 dma data", dma_rdata, exp_dma);
    dma_req = dv; dma_addr = da;
    cpu_valid = cv; cpu_addr = ca; cpu_we = cwe; cpu_be = cbe; cpu_wdata = cwd;
    #1;
    acc = 1'b0;
    pend_cpu = 1'b0;
    pend_dma = dv;
    if (dv) exp_dma = ref_mem[da[AW-1:2]];
    if (cv) begin
      exp_rdy = !(dv && bank_of(da) == bank_of(ca));
      tag = !dv ? "R5 ready" : (exp_rdy ? "R2 ready" : "R3 ready");
      chk(cpu_ready == exp_rdy, tag, DW'(cpu_ready), DW'(exp_rdy));
      acc = cpu_ready;
      if (!cpu_ready) stalls++;
      if (acc && !cwe) begin
        pend_cpu = 1'b1;
        exp_cpu  = ref_mem[ca[AW-1:2]];
      end
      if (acc && cwe) ref_mem[ca[AW-1:2]] = merge(ref_mem[ca[AW-1:2]], cwd, cbe);
    end
  endtask

  task automatic idle();
    logic a;
    cycle(1'b0, '0, 1'b0, '0, 1'b0, '0, '0, a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic          acc;
    logic [AW-1:0] da, ca;
    logic          hv, hwe;
    logic [AW-1:0] ha;
    logic [BW-1:0] hbe;
    logic [DW-1:0] hwd;
    int            s0;
    void'($urandom(32'h1d2c3b4a));
    rst = 1'b1;
    cpu_valid = 1'b1; cpu_addr = '0; cpu_we = 1'b0; cpu_be = '0; cpu_wdata = '0;
    dma_req = 1'b1; dma_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: valid flags stay low under reset despite active requests
    chk(!cpu_rvalid && !dma_rvalid, "R9 reset", DW'({cpu_rvalid, dma_rvalid}), '0);
    rst = 1'b0;
    cpu_valid = 1'b0; dma_req = 1'b0;

    // Fill with the fetch idle: R5 no stalls
    for (int w = 0; w < WORDS; w++) begin
      logic [DW-1:0] d = $urandom;
      cycle(1'b0, '0, 1'b1, AW'(w * 4), 1'b1, '1, d, acc);
    end
    idle();
    chk(stalls == 0, "R5 fill stalls", DW'(stalls), '0);

    // R1: neighbouring chunks differ in bank, chunk two apart shares it
    cycle(1'b1, 12'h000, 1'b1, 12'h010, 1'b0, '0, '0, acc);
    chk(acc == 1'b1, "R1 adjacent chunk", DW'(acc), 1);
    cycle(1'b1, 12'h004, 1'b1, 12'h020, 1'b0, '0, '0, acc);
    chk(acc == 1'b0, "R1 chunk plus two", DW'(acc), 0);
    cycle(1'b0, '0, 1'b1, 12'h020, 1'b0, '0, '0, acc);
    chk(acc == 1'b1, "R1 after fetch idle", DW'(acc), 1);
    idle();

    // R3: fetch parked in bank 0 for three cycles, then moves to bank 1
    s0 = stalls;
    for (int k = 0; k < 3; k++) begin
      cycle(1'b1, AW'(k * 4), 1'b1, 12'h0A4, 1'b1, 4'hF, 32'h5A5A0001, acc);
      chk(acc == 1'b0, "R3 held", DW'(acc), 0);
    end
    cycle(1'b1, 12'h010, 1'b1, 12'h0A4, 1'b1, 4'hF, 32'h5A5A0001, acc);
    chk(acc == 1'b1, "R3 release", DW'(acc), 1);
    chk(stalls - s0 == 3, "R3 stall count", DW'(stalls - s0), 3);
    cycle(1'b1, 12'h0A4 ^ 12'h010, 1'b1, 12'h0A4, 1'b0, '0, '0, acc);
    idle();

    // R7: partial write merges bytes 0 and 2 only
    cycle(1'b0, '0, 1'b1, 12'h100, 1'b1, 4'hF, 32'hAABBCCDD, acc);
    cycle(1'b0, '0, 1'b1, 12'h100, 1'b1, 4'b0101, 32'h11223344, acc);
    cycle(1'b0, '0, 1'b1, 12'h100, 1'b0, '0, '0, acc);
    idle();
    chk(cpu_rdata == 32'hAA22CC44, "R7 byte merge", cpu_rdata, 32'hAA22CC44);

    // R2/R1: fetch streams while the processor stays in the other bank
    s0 = stalls;
    da = 12'h000;
    for (int k = 0; k < 2000; k++) begin
      ca = AW'($urandom) & 12'hFFC;
      ca[4] = ~bank_of(da);
      cycle(1'b1, da, 1'b1, ca, 1'($urandom), 4'($urandom), $urandom, acc);
      da = da + 12'h004;
    end
    idle();
    chk(stalls == s0, "R2 opposite-bank stalls", DW'(stalls - s0), '0);

    // R8/R3/R6: random mixed traffic, processor holds while not ready
    hv = 1'b0; ha = '0; hwe = 1'b0; hbe = '0; hwd = '0;
    da = AW'($urandom) & 12'hFFC;
    for (int k = 0; k < 6000; k++) begin
      logic dv = ($urandom % 10) < 7;
      if (($urandom % 16) == 0) da = AW'($urandom) & 12'hFFC;
      if (!hv && ($urandom % 4) != 0) begin
        hv = 1'b1; ha = AW'($urandom) & 12'hFFC; hwe = 1'($urandom);
        hbe = 4'($urandom); hwd = $urandom;
      end
      cycle(dv, da, hv, ha, hwe, hbe, hwd, acc);
      if (acc) hv = 1'b0;
      if (dv) da = da + 12'h004;
    end
    idle();
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule